// File: doc/BRIEF.md
# Alias-Operated Control Register Bank

This block holds a bank of 32-bit control registers behind a simple two-phase peripheral bus (select, enable, write, address, write data, byte strobes, read data, ready, error). Every register takes up a 16-byte window of the address space. Software can change a register through four word addresses in that window. One replaces the whole value. One ORs the write data into it. One clears the bits that are set in the write data. One XORs the write data into it. The last three let one bus write change selected bits without a software read-modify-write sequence, so two agents can work on different bits of the same register without a race.

A read at any of the four words of a window returns the stored value of that register. All registers are also driven in parallel on a wide output, so downstream logic can use the control bits with no bus traffic. Only whole, aligned 32-bit accesses are accepted. A partial-strobe write or a misaligned access leaves the registers unchanged and raises the error response. An address beyond the last register reads as zero, ignores writes and raises no error. The register count and the address width are parameters.

Top module: `alias_regbank`

## Requirements
- R1: A valid write at window offset 0x0 (address bits [3:2] = 00) replaces the addressed register with the write data.
- R2: A valid write at offset 0x4 (bits [3:2] = 01) ORs the write data into the addressed register.
- R3: A valid write at offset 0x8 (bits [3:2] = 10) clears every register bit whose write-data bit is 1.
- R4: A valid write at offset 0xC (bits [3:2] = 11) XORs the write data into the addressed register.
- R5: The register index is address bits [ADDR_W-1:4]. A read at any of the four offsets of an in-range window returns that register's stored value with the error response low.
- R6: A synchronous active-low reset sets every register to zero.
- R7: A write whose byte strobe is not 4'b1111 changes no register and drives the error response high during its access cycle.
- R8: An access with address bits [1:0] not 00 raises the error response. As a write it changes no register. As a read it returns zero.
- R9: An aligned access whose register index is NUM_SLOTS or more reads as zero, changes no register, and keeps the error response low.
- R10: A write takes effect at the clock edge that ends its access cycle (select and enable both high). From the next cycle the parallel output and any read show the new value.
- R11: Ready is high in every access cycle, so each transfer completes in one access cycle.
- R12: No register changes in a cycle unless select, enable and write are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access-phase enable |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_strb | input | 4 | Byte strobes for a write |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_ready | output | 1 | Transfer completes this cycle |
| bus_err | output | 1 | Error response for a rejected access |
| ctrl_q | output | 32*NUM_SLOTS | All registers; register i sits in bits [32*i+31:32*i] |

## Verification
Read data, ready and error are combinational in the access cycle. The bench samples them one time unit after the falling edge that starts that cycle, which is before the edge that commits the transfer. A register update is due one clock edge after the access cycle begins. The bench folds it into its reference model just after that rising edge. It then compares the whole parallel output against the model at every falling edge, so an update that lands a cycle early or late, or that lands when it should not, shows up within one cycle.

// File: rtl/alias_regbank_pkg.sv
// Shared definitions for the alias-operated register bank.
// Assumes a 32-bit data path with four byte strobes.
package alias_regbank_pkg;
    localparam int WORD_W = 32;
    localparam int STRB_W = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    // Operation selected by address bits [3:2] inside a 16-byte window
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_OR      = 2'd1,
        OP_ANDNOT  = 2'd2,
        OP_XOR     = 2'd3
    } alias_op_e;
endpackage

// File: rtl/arb_decode.sv
// Address decoder: splits a byte address into register index, alias
// operation and access-legality flags. Purely combinational.
// Assumes ADDR_W >= 5 so that at least one index bit exists.
module arb_decode
    import alias_regbank_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_SLOTS = 8,
    localparam int FIELD_W  = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] strb,
    input  logic              wr,
    output logic [FIELD_W-1:0] field,
    output alias_op_e         op,
    output logic              in_range,
    output logic              reject
);
    logic misaligned;
    logic partial;

    // Split address into index and operation; classify legality
    always_comb begin
        field      = addr[ADDR_W-1:4];
        op         = alias_op_e'(addr[3:2]);
        in_range   = ({1'b0, addr[ADDR_W-1:4]} < (FIELD_W+1)'(NUM_SLOTS));
        misaligned = (addr[1:0] != 2'b00);
        partial    = wr && (strb != {STRB_W{1'b1}});
        reject     = misaligned || partial;
    end
endmodule

// File: rtl/arb_rmw.sv
// Read-modify-write unit: combines the current word and the bus data
// according to the alias operation. Shared by all registers.
module arb_rmw
    import alias_regbank_pkg::*;
(
    input  alias_op_e op,
    input  word_t     cur,
    input  word_t     data,
    output word_t     nxt
);
    // Choose the update rule for the addressed alias
    always_comb begin
        unique case (op)
            OP_REPLACE: nxt = data;
            OP_OR:      nxt = cur | data;
            OP_ANDNOT:  nxt = cur & ~data;
            OP_XOR:     nxt = cur ^ data;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/arb_slot.sv
// One storage register with synchronous active-low reset and load enable.
module arb_slot
    import alias_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t d,
    output word_t q
);
    // Hold, load or clear the stored word
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/alias_regbank.sv
// Top of the alias-operated register bank. Decodes the bus access, reads
// the addressed register through a mux, passes it through one shared RMW
// unit and loads the result into the single enabled register.
// Assumes a zero-wait bus: every access cycle completes.
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_SLOTS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_en,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic [3:0]                  bus_strb,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_ready,
    output logic                        bus_err,
    output logic [32*NUM_SLOTS-1:0]     ctrl_q
);
    localparam int FIELD_W = ADDR_W - 4;

    logic [FIELD_W-1:0] field;
    alias_op_e          op;
    logic               in_range;
    logic               reject;
    logic               access;
    logic               commit;
    word_t              cur_word;
    word_t              nxt_word;
    word_t              slot_q   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_hit;

    arb_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr     (bus_addr),
        .strb     (bus_strb),
        .wr       (bus_wr),
        .field    (field),
        .op       (op),
        .in_range (in_range),
        .reject   (reject)
    );

    // Access phase and write commit qualification
    always_comb begin
        access = bus_sel && bus_en;
        commit = access && bus_wr && !reject && in_range;
    end

    // One slot per register, each with its own index match
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_hit[i] = (field == FIELD_W'(i));

        arb_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (commit && slot_hit[i]),
            .d     (nxt_word),
            .q     (slot_q[i])
        );

        assign ctrl_q[32*i +: 32] = slot_q[i];
    end

    // Select the addressed register's current value
    always_comb begin
        cur_word = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot_hit[k]) cur_word = slot_q[k];
        end
    end

    arb_rmw u_rmw (
        .op   (op),
        .cur  (cur_word),
        .data (bus_wdata),
        .nxt  (nxt_word)
    );

    // Bus response: read data, error flag and zero-wait ready
    always_comb begin
        bus_ready = 1'b1;
        bus_err   = access && reject;
        bus_rdata = (access && !bus_wr && !reject && in_range) ? cur_word : '0;
    end
endmodule

// File: rtl/alias_regbank_chk.sv
// Property checker for alias_regbank, attached to every instance by bind.
// Captures each committed write and checks its effect one cycle later.
module alias_regbank_chk #(
    parameter int ADDR_W    = 10,
    parameter int NUM_SLOTS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    bus_en,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [3:0]              bus_strb,
    input logic [31:0]             bus_rdata,
    input logic                    bus_ready,
    input logic                    bus_err,
    input logic [32*NUM_SLOTS-1:0] ctrl_q
);
    localparam int FIELD_W = ADDR_W - 4;

    logic               good_wr;
    logic               oor;
    logic               cap_v;
    logic [1:0]         cap_op;
    logic [FIELD_W-1:0] cap_idx;
    logic [31:0]        cap_mask;
    logic [31:0]        cap_word;

    // Classify the present access independently of the design's decoder
    always_comb begin
        oor     = ({1'b0, bus_addr[ADDR_W-1:4]} >= (FIELD_W+1)'(NUM_SLOTS));
        good_wr = bus_sel && bus_en && bus_wr && bus_strb == 4'hF
                  && bus_addr[1:0] == 2'b00 && !oor;
    end

    // Remember the last committed write for the next-cycle check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v    <= 1'b0;
            cap_op   <= '0;
            cap_idx  <= '0;
            cap_mask <= '0;
        end else begin
            cap_v    <= good_wr;
            cap_op   <= bus_addr[3:2];
            cap_idx  <= bus_addr[ADDR_W-1:4];
            cap_mask <= bus_wdata;
        end
    end

    // Pick the register the captured write addressed
    always_comb begin
        cap_word = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (cap_idx == FIELD_W'(k)) cap_word = ctrl_q[32*k +: 32];
        end
    end

    // R6
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> ctrl_q == '0);

    // R7
    strobe_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && bus_wr && bus_strb != 4'hF) |-> bus_err);

    // R8
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && bus_addr[1:0] != 2'b00) |-> (bus_err && (bus_wr || bus_rdata == '0)));

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && bus_err) |=> $stable(ctrl_q));

    // R9
    range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en && oor && bus_addr[1:0] == 2'b00 && (!bus_wr || bus_strb == 4'hF))
        |-> (!bus_err && (bus_wr || bus_rdata == '0)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_en && bus_wr) |=> $stable(ctrl_q));

    // R11
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_en) |-> bus_ready);

    // R1
    replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_v && cap_op == 2'd0) |-> cap_word == cap_mask);

    // R2
    or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_v && cap_op == 2'd1) |-> (cap_word & cap_mask) == cap_mask);

    // R3
    andnot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_v && cap_op == 2'd2) |-> (cap_word & cap_mask) == '0);
endmodule

bind alias_regbank alias_regbank_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/tb_alias_regbank.sv
// Self-checking bench: a behavioural model of the bank, updated per bus
// transfer and compared against the parallel output on every clock.
module tb_alias_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int NUM_SLOTS  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_sel = 1'b0;
    logic                    bus_en = 1'b0;
    logic                    bus_wr = 1'b0;
    logic [ADDR_W-1:0]       bus_addr = '0;
    logic [31:0]             bus_wdata = '0;
    logic [3:0]              bus_strb = '0;
    logic [31:0]             bus_rdata;
    logic                    bus_ready;
    logic                    bus_err;
    logic [32*NUM_SLOTS-1:0] ctrl_q;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    logic [31:0] model [NUM_SLOTS];

    alias_regbank #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison of every register against the model (R10, R12)
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                check(ctrl_q[32*i +: 32] === model[i], "R10/R12 parallel output", ctrl_q[32*i +: 32], model[i]);
            end
        end
    end

    // Behavioural effect of a transfer on the model
    task automatic model_apply(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        int idx;
        idx = int'(a >> 4);
        if (idx >= NUM_SLOTS) return;
        case (a[3:2])
            2'd0: model[idx] = d;
            2'd1: model[idx] = model[idx] | d;
            2'd2: model[idx] = model[idx] & ~d;
            default: model[idx] = model[idx] ^ d;
        endcase
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] s, input string req);
        bit bad;
        bad = (a[1:0] != 2'b00) || (s != 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1;
        bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_en = 1'b1;
        #1;
        check(bus_err === bad, {req, " write err"}, 32'(bus_err), 32'(bad));
        check(bus_ready === 1'b1, "R11 ready", 32'(bus_ready), 32'd1);
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        if (!bad) model_apply(a, d);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input string req);
        bit bad;
        logic [31:0] exp;
        int idx;
        bad = (a[1:0] != 2'b00);
        idx = int'(a >> 4);
        exp = (bad || idx >= NUM_SLOTS) ? 32'h0 : model[idx];
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0;
        bus_addr = a; bus_strb = 4'h0;
        @(negedge clk);
        bus_en = 1'b1;
        #1;
        check(bus_rdata === exp, {req, " read data"}, bus_rdata, exp);
        check(bus_err === bad, {req, " read err"}, 32'(bus_err), 32'(bad));
        check(bus_ready === 1'b1, "R11 ready", 32'(bus_ready), 32'd1);
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_en = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int idx, input int off);
        return ADDR_W'(idx * 16 + off);
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM_SLOTS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R6: reset state
        for (int i = 0; i < NUM_SLOTS; i++) bus_read(mk(i, 0), "R6 reset zero");

        // R1, R10: replace then read the next cycle at every alias (R5)
        bus_write(mk(2, 0), 32'hA5A5_0F0F, 4'hF, "R1");
        for (int o = 0; o < 16; o += 4) bus_read(mk(2, o), "R5 alias read");
        // R2: OR
        bus_write(mk(2, 4), 32'h0000_F000, 4'hF, "R2");
        bus_read(mk(2, 0), "R2 or result");
        // R3: clear
        bus_write(mk(2, 8), 32'hA000_000F, 4'hF, "R3");
        bus_read(mk(2, 12), "R3 clear result");
        // R4: toggle twice restores
        bus_write(mk(2, 12), 32'hFFFF_FFFF, 4'hF, "R4");
        bus_read(mk(2, 4), "R4 toggle result");
        bus_write(mk(2, 12), 32'hFFFF_FFFF, 4'hF, "R4");
        bus_read(mk(2, 8), "R4 toggle back");

        // R7: partial strobes rejected
        bus_write(mk(3, 0), 32'h1234_5678, 4'h3, "R7");
        bus_write(mk(2, 4), 32'hFFFF_FFFF, 4'h0, "R7");
        bus_read(mk(3, 0), "R7 unchanged");
        bus_read(mk(2, 0), "R7 unchanged");
        // R8: misaligned write and read
        bus_write(mk(4, 1), 32'hDEAD_BEEF, 4'hF, "R8");
        bus_read(mk(4, 0), "R8 unchanged");
        bus_read(mk(2, 2), "R8 misaligned read");
        // R9: beyond the last register
        bus_write(mk(NUM_SLOTS, 0), 32'hFFFF_0000, 4'hF, "R9");
        bus_write(mk(NUM_SLOTS + 5, 4), 32'h0000_FFFF, 4'hF, "R9");
        bus_read(mk(NUM_SLOTS, 0), "R9 oor read");
        bus_read(mk(NUM_SLOTS + 5, 4), "R9 oor read");
        // Boundary: last register and first register
        bus_write(mk(NUM_SLOTS - 1, 0), 32'h8000_0001, 4'hF, "R1");
        bus_write(mk(0, 4), 32'h0000_0003, 4'hF, "R2");
        bus_read(mk(NUM_SLOTS - 1, 8), "R5 last slot");
        bus_read(mk(0, 12), "R5 first slot");

        // R12: setup phase alone or enable without select writes nothing
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1;
        bus_addr = mk(5, 0); bus_wdata = 32'hFFFF_FFFF; bus_strb = 4'hF;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        bus_read(mk(5, 0), "R12 no transfer");

        // Random mix across all aliases, some illegal or out of range
        for (int n = 0; n < 400; n++) begin
            int idx;
            int off;
            logic [3:0] s;
            idx = int'($urandom_range(0, NUM_SLOTS + 1));
            off = int'($urandom_range(0, 3)) * 4;
            if ($urandom_range(0, 15) == 0) off += int'($urandom_range(1, 3));
            s = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            if ($urandom_range(0, 2) != 0)
                bus_write(mk(idx, off), $urandom(), s, "R1-4 random");
            else
                bus_read(mk(idx, off), "R5 random");
        end

        // R6: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int i = 0; i < NUM_SLOTS; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NUM_SLOTS; i++) bus_read(mk(i, 4), "R6 reset again");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule